// File: doc/BRIEF.md
# Masked serial slave address filter

On a multidrop serial bus many nodes share one receive line, and a master marks address frames with a qualifier bit. This block sits at the end of a node's receiver. When the receiver signals that a byte is complete, the block decides whether a receive interrupt should be raised. In multiprocessor operation an interrupt is raised only when the byte addresses this node. Otherwise every completed byte raises one.

The node holds two configuration registers: an address and a mask. A mask bit of 0 makes the matching address bit don't-care. The bitwise OR of address and mask forms a second, broadcast pattern, and every 0 bit of that OR is don't-care. A byte is accepted if it fits either pattern. The qualifier is the ninth data bit in the 9-bit modes and the stop bit in the 8-bit mode. In shift-register mode, multiprocessor operation cannot be enabled.

Top module: `slave_addr_filter`

## Requirements
- R1: Individual pattern. With multiprocessor operation active and the qualifier at 1, a byte is accepted when it equals the address register at every bit position where the mask register holds 1. Bits where the mask holds 0 are ignored.
- R2: A mask of 0xFF turns the individual pattern into an exact 8-bit compare. For example, with address 0x3C only 0x3C is accepted by that pattern, and 0x3D is rejected.
- R3: Broadcast pattern. The reference is address OR mask. A byte is accepted when it holds a 1 wherever that OR holds a 1. For address 0x56 and mask 0xFC, both 0xFE and 0xFF are accepted.
- R4: A byte is accepted if either pattern fits. It is rejected when neither fits.
- R5: In the 9-bit modes (`ser_mode` 2'b10 and 2'b11) with `mp_en` at 1, `rx_irq_set` is raised only when the qualifier (ninth bit) is 1 and the byte is accepted.
- R6: In the 8-bit mode (`ser_mode` 2'b01) with `mp_en` at 1, the qualifier is the stop bit. `rx_irq_set` is raised only for an accepted byte whose stop bit is 1.
- R7: In shift-register mode (`ser_mode` 2'b00), `mp_en` has no effect. Every `frame_done` pulse raises `rx_irq_set`, whatever the byte and qualifier.
- R8: With `mp_en` at 0, `rx_irq_set` follows `frame_done` in every mode.
- R9: Both the address and mask registers reset to 0x00. Straight after reset, every byte with qualifier 1 is therefore accepted.
- R10: `rx_irq_set` is combinational and asserts only in a cycle where `frame_done` is 1, so it lasts one cycle per one-cycle strobe.
- R11: A write takes effect from the clock edge that samples it. `addr_wr_en` loads `cfg_wdata` into the address register, and `mask_wr_en` loads it into the mask register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_wr_en | input | 1 | Load address register from cfg_wdata |
| mask_wr_en | input | 1 | Load mask register from cfg_wdata |
| cfg_wdata | input | 8 | Configuration write data |
| mp_en | input | 1 | Multiprocessor address filtering enable |
| ser_mode | input | 2 | 00 shift, 01 8-bit, 10/11 9-bit |
| frame_done | input | 1 | One-cycle strobe: a byte has been received |
| rx_byte | input | 8 | Received byte |
| rx_qual | input | 1 | Ninth bit (9-bit modes) or stop bit (8-bit mode) |
| rx_irq_set | output | 1 | Gated receive-interrupt set pulse |

## Verification
The only internal state is the address and mask register pair. If either register is wrong, the fault shows up in the same cycle as the next `frame_done` pulse: a byte is accepted or rejected wrongly. The bench therefore probes bytes on both sides of every don't-care boundary, right after each write. This includes the byte just outside the masked range and the broadcast bytes. A wrong reset value shows up on the first probe after reset. That probe uses a byte that a zero configuration accepts and that most other configurations reject.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;

    localparam int ADDR_W = 8;

    typedef enum logic [1:0] {
        MODE_SHIFT  = 2'b00,
        MODE_UART8  = 2'b01,
        MODE_UART9F = 2'b10,
        MODE_UART9V = 2'b11
    } ser_mode_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] mask;
    } node_cfg_t;

endpackage

// File: rtl/node_cfg_regs.sv
module node_cfg_regs
    import addr_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_wr_en,
    input  logic              mask_wr_en,
    input  logic [ADDR_W-1:0] cfg_wdata,
    output node_cfg_t         cfg
);

    node_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (addr_wr_en) cfg_d.addr = cfg_wdata;
        if (mask_wr_en) cfg_d.mask = cfg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/addr_pattern_match.sv
module addr_pattern_match #(
    parameter int W         = 8,
    parameter bit BROADCAST = 1'b0
) (
    input  logic [W-1:0] addr,
    input  logic [W-1:0] mask,
    input  logic [W-1:0] rx_byte,
    output logic         hit
);

    logic [W-1:0] bit_ok;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (BROADCAST) begin : g_bc
            // reference bit is addr|mask; a 0 there is don't-care
            assign bit_ok[i] = ~(addr[i] | mask[i]) | rx_byte[i];
        end else begin : g_ind
            // mask 0 is don't-care, mask 1 demands equality
            assign bit_ok[i] = ~mask[i] | ~(rx_byte[i] ^ addr[i]);
        end
    end

    assign hit = &bit_ok;

endmodule

// File: rtl/irq_gate.sv
module irq_gate
    import addr_filt_pkg::*;
(
    input  logic [1:0] ser_mode,
    input  logic       mp_en,
    input  logic       frame_done,
    input  logic       rx_qual,
    input  logic       ind_hit,
    input  logic       bc_hit,
    output logic       irq_set
);

    logic filtering;

    always_comb begin
        filtering = mp_en && (ser_mode != MODE_SHIFT);
        if (filtering) irq_set = frame_done && rx_qual && (ind_hit || bc_hit);
        else           irq_set = frame_done;
    end

endmodule

// File: rtl/slave_addr_filter.sv
module slave_addr_filter
    import addr_filt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_wr_en,
    input  logic              mask_wr_en,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              mp_en,
    input  logic [1:0]        ser_mode,
    input  logic              frame_done,
    input  logic [ADDR_W-1:0] rx_byte,
    input  logic              rx_qual,
    output logic              rx_irq_set
);

    node_cfg_t         cfg;
    logic [ADDR_W-1:0] cfg_addr;
    logic [ADDR_W-1:0] cfg_mask;
    logic              ind_hit;
    logic              bc_hit;

    node_cfg_regs i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_wr_en (addr_wr_en),
        .mask_wr_en (mask_wr_en),
        .cfg_wdata  (cfg_wdata),
        .cfg        (cfg)
    );

    assign cfg_addr = cfg.addr;
    assign cfg_mask = cfg.mask;

    addr_pattern_match #(.W(ADDR_W), .BROADCAST(1'b0)) i_ind (
        .addr    (cfg_addr),
        .mask    (cfg_mask),
        .rx_byte (rx_byte),
        .hit     (ind_hit)
    );

    addr_pattern_match #(.W(ADDR_W), .BROADCAST(1'b1)) i_bc (
        .addr    (cfg_addr),
        .mask    (cfg_mask),
        .rx_byte (rx_byte),
        .hit     (bc_hit)
    );

    irq_gate i_gate (
        .ser_mode   (ser_mode),
        .mp_en      (mp_en),
        .frame_done (frame_done),
        .rx_qual    (rx_qual),
        .ind_hit    (ind_hit),
        .bc_hit     (bc_hit),
        .irq_set    (rx_irq_set)
    );

endmodule

// File: rtl/slave_addr_filter_chk.sv
module slave_addr_filter_chk
    import addr_filt_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              addr_wr_en,
    input logic              mask_wr_en,
    input logic [ADDR_W-1:0] cfg_wdata,
    input logic              mp_en,
    input logic [1:0]        ser_mode,
    input logic              frame_done,
    input logic [ADDR_W-1:0] rx_byte,
    input logic              rx_qual,
    input logic              rx_irq_set,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [ADDR_W-1:0] cfg_mask
);

    logic accept_ref;
    assign accept_ref = ((rx_byte & cfg_mask) == (cfg_addr & cfg_mask))
                     || ((rx_byte & (cfg_addr | cfg_mask)) == (cfg_addr | cfg_mask));

    // R10: no pulse without the strobe
    assert_no_stray_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_done |-> !rx_irq_set);

    // R7: shift mode always passes the strobe
    assert_shift_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && ser_mode == MODE_SHIFT) |-> rx_irq_set);

    // R8: filtering off passes the strobe
    assert_mp_off_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !mp_en) |-> rx_irq_set);

    // R5 / R6: a qualifier of 0 blocks the pulse when filtering
    assert_qual_gate_R5_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mp_en && ser_mode != MODE_SHIFT && !rx_qual) |-> !rx_irq_set);

    // R4: filtered pulse only on an accepted byte, always on one
    assert_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mp_en && ser_mode != MODE_SHIFT && frame_done && rx_qual) |-> (rx_irq_set == accept_ref));

    // R11: writes land on the sampling edge
    assert_addr_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        addr_wr_en |=> (cfg_addr == $past(cfg_wdata)));
    assert_mask_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mask_wr_en |=> (cfg_mask == $past(cfg_wdata)));

endmodule

bind slave_addr_filter slave_addr_filter_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .addr_wr_en (addr_wr_en),
    .mask_wr_en (mask_wr_en),
    .cfg_wdata  (cfg_wdata),
    .mp_en      (mp_en),
    .ser_mode   (ser_mode),
    .frame_done (frame_done),
    .rx_byte    (rx_byte),
    .rx_qual    (rx_qual),
    .rx_irq_set (rx_irq_set),
    .cfg_addr   (cfg_addr),
    .cfg_mask   (cfg_mask)
);

// File: tb/test_slave_addr_filter.sv
`timescale 1ns/1ps
module test_slave_addr_filter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       addr_wr_en = 1'b0;
    logic       mask_wr_en = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic       mp_en = 1'b0;
    logic [1:0] ser_mode = 2'b00;
    logic       frame_done = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rx_qual = 1'b0;
    logic       rx_irq_set;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    slave_addr_filter i_slave_addr_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_wr_en (addr_wr_en),
        .mask_wr_en (mask_wr_en),
        .cfg_wdata  (cfg_wdata),
        .mp_en      (mp_en),
        .ser_mode   (ser_mode),
        .frame_done (frame_done),
        .rx_byte    (rx_byte),
        .rx_qual    (rx_qual),
        .rx_irq_set (rx_irq_set)
    );

    task automatic check(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: rx_irq_set=%b expected %b", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] a, input logic [7:0] m);
        @(negedge clk);
        addr_wr_en = 1'b1; cfg_wdata = a;
        @(negedge clk);
        addr_wr_en = 1'b0; mask_wr_en = 1'b1; cfg_wdata = m;
        @(negedge clk);
        mask_wr_en = 1'b0;
    endtask

    // one strobe; output sampled mid-cycle, then the following idle cycle
    task automatic probe(input logic [1:0] mode, input logic mp, input logic [7:0] b,
                         input logic q, input logic exp, input string req);
        @(negedge clk);
        ser_mode = mode; mp_en = mp; rx_byte = b; rx_qual = q; frame_done = 1'b1;
        #1 check(rx_irq_set, exp, req);
        @(negedge clk);
        frame_done = 1'b0;
        #1 check(rx_irq_set, 1'b0, "R10 pulse ends");
    endtask

    task automatic t_reset;
        #1 check(rx_irq_set, 1'b0, "R10 idle in reset");
        probe(2'b11, 1'b1, 8'hA5, 1'b1, 1'b1, "R9 zero config accepts any");
        probe(2'b10, 1'b1, 8'h00, 1'b1, 1'b1, "R9 zero config accepts 0x00");
    endtask

    task automatic t_masked;
        write_cfg(8'h56, 8'hFC);
        for (int b = 8'h54; b <= 8'h57; b++)
            probe(2'b11, 1'b1, 8'(b), 1'b1, 1'b1, "R1 masked range accept");
        probe(2'b11, 1'b1, 8'h58, 1'b1, 1'b0, "R1 outside range reject");
        probe(2'b11, 1'b1, 8'h53, 1'b1, 1'b0, "R4 neither pattern reject");
        probe(2'b11, 1'b1, 8'hFE, 1'b1, 1'b1, "R3 broadcast 0xFE");
        probe(2'b11, 1'b1, 8'hFF, 1'b1, 1'b1, "R3 broadcast 0xFF");
        probe(2'b11, 1'b1, 8'hFC, 1'b1, 1'b0, "R3 broadcast needs bit1");
    endtask

    task automatic t_exact;
        write_cfg(8'h3C, 8'hFF);
        probe(2'b10, 1'b1, 8'h3C, 1'b1, 1'b1, "R2 exact hit");
        probe(2'b10, 1'b1, 8'h3D, 1'b1, 1'b0, "R2 exact miss");
        probe(2'b10, 1'b1, 8'hFF, 1'b1, 1'b1, "R3 broadcast with full mask");
    endtask

    task automatic t_multi_slave;
        write_cfg(8'hF1, 8'hFA);
        probe(2'b11, 1'b1, 8'hF0, 1'b1, 1'b1, "R1 slave A takes F0");
        probe(2'b11, 1'b1, 8'hFB, 1'b1, 1'b1, "R4 slave A broadcast FB");
        write_cfg(8'hF3, 8'hFD);
        probe(2'b11, 1'b1, 8'hF0, 1'b1, 1'b0, "R1 slave C refuses F0");
        probe(2'b11, 1'b1, 8'hF1, 1'b1, 1'b1, "R1 slave C takes F1");
        probe(2'b11, 1'b1, 8'hFB, 1'b1, 1'b0, "R4 slave C refuses FB");
    endtask

    task automatic t_qual_modes;
        write_cfg(8'h56, 8'hFF);
        probe(2'b10, 1'b1, 8'h56, 1'b0, 1'b0, "R5 ninth bit 0 blocks");
        probe(2'b11, 1'b1, 8'h56, 1'b0, 1'b0, "R5 ninth bit 0 blocks mode3");
        probe(2'b01, 1'b1, 8'h56, 1'b1, 1'b1, "R6 valid stop accepts");
        probe(2'b01, 1'b1, 8'h56, 1'b0, 1'b0, "R6 bad stop blocks");
        probe(2'b01, 1'b1, 8'h57, 1'b1, 1'b0, "R6 address miss blocks");
    endtask

    task automatic t_passthru;
        probe(2'b00, 1'b1, 8'h12, 1'b0, 1'b1, "R7 shift mode ignores filter");
        probe(2'b00, 1'b0, 8'h99, 1'b1, 1'b1, "R7 shift mode plain");
        probe(2'b11, 1'b0, 8'h00, 1'b0, 1'b1, "R8 filter off mode3");
        probe(2'b01, 1'b0, 8'h57, 1'b0, 1'b1, "R8 filter off mode1");
    endtask

    task automatic t_write_timing;
        @(negedge clk);
        addr_wr_en = 1'b1; mask_wr_en = 1'b1; cfg_wdata = 8'h81;
        @(negedge clk);
        addr_wr_en = 1'b0; mask_wr_en = 1'b0; cfg_wdata = 8'h00;
        probe(2'b10, 1'b1, 8'h81, 1'b1, 1'b1, "R11 joint write hit");
        probe(2'b10, 1'b1, 8'h80, 1'b1, 1'b0, "R11 joint write miss");
    endtask

    initial begin
        #4000000;
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_masked();
        t_exact();
        t_multi_slave();
        t_qual_modes();
        t_passthru();
        t_write_timing();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule